// File: doc/BRIEF.md
# Two-Input Edge/Level External Interrupt with Wake Sequencing

This block takes two external request pins and turns each into an interrupt request. A two-bit sense code per input selects one of four behaviours: a low level, any change, a falling edge or a rising edge. In the three edge modes a change is first carried through a two-flop synchronizer running on the I/O clock. It then sets a sticky per-input flag. Software clears the flag by writing a one, or the flag clears when the interrupt is acknowledged. In low-level mode no flag is used: the request follows the inverted pin directly, with no clock in the path, for as long as the pin stays low.

The block also models the power sequence around it. A sleep request stops the I/O clock, which freezes edge recognition. While the clock is stopped, only an enabled low-level input can raise the wake output. The wake starts a start-up count of 0, 4, 64 or 1024 clocks, chosen by a two-bit setting. Interrupt requests are held off until the count ends. A level request that has gone away by then therefore never reaches the core, even though the system did wake. The pin value seen here is the pad's sensed level, so a pin driven as an output still triggers, which gives software a way to raise its own interrupt.

Top module: `ext_irq_ctrl`

## Requirements
- R1: During and right after reset every flag is 0, every request is 0, the wake output is 0 and both the run and I/O-clock indicators are 1.
- R2: With sense code 2'b10 (sense_i[2i+1:2i] for input i), a high-to-low change on the pin sets that input's flag on the third clock edge after the change is first sampled; a low-to-high change does not set it.
- R3: With sense code 2'b11, a low-to-high change sets the flag with the same latency as R2; a high-to-low change does not.
- R4: With sense code 2'b01, a change in either direction sets the flag with the same latency as R2.
- R5: With sense code 2'b00, the flag is never set, and while running, the request for input i equals en_i[i] AND NOT pin_i[i] combinationally, with no latching.
- R6: A one on flag_w1c_i[i] or ack_i[i] at a clock edge clears flag i, unless a qualifying edge sets it at the same edge, in which case the flag stays set.
- R7: In edge modes the request for input i is en_i[i] AND flag i; a disabled input still records its flag.
- R8: A one on sleep_req_i while running stops the I/O clock (io_clk_o = 0). Pin changes while the clock is stopped set no flag, and none is recognised in the first three clocks after the clock restarts.
- R9: wake_o is 1 only while asleep, and exactly when some enabled input in sense code 2'b00 has its pin low; inputs in edge modes never wake the block.
- R10: After a wake, the block spends D clocks in start-up before run_o returns to 1, where startup_sel_i 0, 1, 2, 3 gives D = 0, 4, 64, 1024; the setting is sampled at the wake edge.
- R11: A level wake whose pin has returned high before the start-up count ends produces no request once running.
- R12: All requests are 0 whenever run_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 2 | Sensed pad levels of the interrupt inputs |
| sense_i | input | 4 | Two-bit sense code per input |
| en_i | input | 2 | Per-input request enable |
| flag_w1c_i | input | 2 | Write-one-to-clear strobe per flag |
| ack_i | input | 2 | Interrupt acknowledge per input |
| sleep_req_i | input | 1 | Request to stop the I/O clock |
| startup_sel_i | input | 2 | Start-up delay selection |
| irq_o | output | 2 | Interrupt requests to the core |
| flag_o | output | 2 | Edge flags |
| wake_o | output | 1 | Asynchronous wake request while asleep |
| run_o | output | 1 | Core running (not asleep, not in start-up) |
| io_clk_o | output | 1 | I/O clock running |

## Verification
The assertions assume that the pins and controls change only away from the sampling edge and hold steady through it. This lets the latency check relate a flag rise to pin samples three and four clocks back. The bench meets this by driving every input on the falling clock edge. Flag-rise checks also assume that the sense code stays fixed while a change is in flight, so the stimulus waits several clocks after each mode change before it moves a pin. Asynchronous pin pulses shorter than a clock are not used, because the edge path cannot see them by design.

// File: rtl/ext_irq_pkg.sv
// Shared encodings for the external interrupt block.
// Assumes: sense codes are fixed by the register layout that software uses.
package ext_irq_pkg;
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'b00,
        PWR_SLEEP = 2'b01,
        PWR_START = 2'b10
    } pwr_e;
endpackage

// File: rtl/ext_irq_sync_edge.sv
// Pin synchronizer and edge history for one input, clocked by the gated I/O clock.
// Assumes: SYNC_STAGES >= 2; clk_en_i low models a stopped I/O clock.
// valid_o is low until every history flop holds a sample taken after the
// last clock restart, so stale pre-sleep values never look like an edge.
module ext_irq_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en_i,
    input  logic pin_i,
    output logic cur_o,
    output logic prev_o,
    output logic valid_o
);
    localparam int WARM_W = SYNC_STAGES + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [WARM_W-1:0]      warm_q;

    // Shift the pin through the synchronizer while the I/O clock runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else if (clk_en_i) begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Count fresh samples since the clock last restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !clk_en_i) begin
            warm_q <= '0;
        end else begin
            warm_q <= {warm_q[WARM_W-2:0], 1'b1};
        end
    end

    assign cur_o   = sync_q[SYNC_STAGES-1];
    assign prev_o  = prev_q;
    assign valid_o = warm_q[WARM_W-1] & clk_en_i;
endmodule

// File: rtl/ext_irq_channel.sv
// One interrupt input: sense decode, sticky edge flag and request output.
// Assumes: run_i gates requests while asleep or starting up; the level path
// is combinational from the pin so it works with the I/O clock stopped.
module ext_irq_channel
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en_i,
    input  logic       run_i,
    input  logic       pin_i,
    input  logic [1:0] sense_i,
    input  logic       en_i,
    input  logic       w1c_i,
    input  logic       ack_i,
    output logic       flag_o,
    output logic       irq_o,
    output logic       level_low_o
);
    sense_e mode;
    logic   cur, prev, hist_ok;
    logic   hit, set_flag;
    logic   flag_q;

    assign mode = sense_e'(sense_i);

    ext_irq_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_i (clk_en_i),
        .pin_i    (pin_i),
        .cur_o    (cur),
        .prev_o   (prev),
        .valid_o  (hist_ok)
    );

    // Decide whether the synchronized history matches the selected edge.
    always_comb begin
        case (mode)
            SNS_ANY:  hit = cur ^ prev;
            SNS_FALL: hit = prev & ~cur;
            SNS_RISE: hit = ~prev & cur;
            default:  hit = 1'b0;
        endcase
    end

    assign set_flag = hit & hist_ok;

    // Sticky flag: a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_flag) begin
            flag_q <= 1'b1;
        end else if (w1c_i || ack_i) begin
            flag_q <= 1'b0;
        end
    end

    assign level_low_o = en_i & (mode == SNS_LOW) & ~pin_i;
    assign flag_o      = flag_q;
    assign irq_o       = run_i & ((mode == SNS_LOW) ? level_low_o : (en_i & flag_q));
endmodule

// File: rtl/ext_irq_wake_ctrl.sv
// Sleep/wake sequencer with a programmable start-up down-counter.
// Assumes: the only wake source modelled is the level request from the
// channels; DLY_3 is the largest delay and sizes the counter.
module ext_irq_wake_ctrl
    import ext_irq_pkg::*;
#(
    parameter int DLY_1 = 4,
    parameter int DLY_2 = 64,
    parameter int DLY_3 = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req_i,
    input  logic       wake_req_i,
    input  logic [1:0] dly_sel_i,
    output logic       run_o,
    output logic       io_clk_en_o,
    output logic       asleep_o
);
    localparam int CNT_W = (DLY_3 > 2) ? $clog2(DLY_3) : 1;

    pwr_e             state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Counter preload is the delay minus one, so START lasts exactly D clocks.
    always_comb begin
        case (dly_sel_i)
            2'd1:    load_val = CNT_W'(DLY_1 - 1);
            2'd2:    load_val = CNT_W'(DLY_2 - 1);
            2'd3:    load_val = CNT_W'(DLY_3 - 1);
            default: load_val = '0;
        endcase
    end

    // Power state transitions and start-up countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_RUN;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                PWR_RUN: begin
                    if (sleep_req_i) state_q <= PWR_SLEEP;
                end
                PWR_SLEEP: begin
                    if (wake_req_i) begin
                        if (dly_sel_i == 2'd0) begin
                            state_q <= PWR_RUN;
                        end else begin
                            state_q <= PWR_START;
                            cnt_q   <= load_val;
                        end
                    end
                end
                PWR_START: begin
                    if (cnt_q == '0) state_q <= PWR_RUN;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= PWR_RUN;
            endcase
        end
    end

    assign run_o       = (state_q == PWR_RUN);
    assign asleep_o    = (state_q == PWR_SLEEP);
    assign io_clk_en_o = ~asleep_o;
endmodule

// File: rtl/ext_irq_ctrl.sv
// Top level: replicated interrupt channels plus the wake sequencer.
// Assumes: pins may change at any time; control inputs are synchronous to clk.
module ext_irq_ctrl #(
    parameter int NUM_IN      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DLY_1       = 4,
    parameter int DLY_2       = 64,
    parameter int DLY_3       = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   pin_i,
    input  logic [2*NUM_IN-1:0] sense_i,
    input  logic [NUM_IN-1:0]   en_i,
    input  logic [NUM_IN-1:0]   flag_w1c_i,
    input  logic [NUM_IN-1:0]   ack_i,
    input  logic                sleep_req_i,
    input  logic [1:0]          startup_sel_i,
    output logic [NUM_IN-1:0]   irq_o,
    output logic [NUM_IN-1:0]   flag_o,
    output logic                wake_o,
    output logic                run_o,
    output logic                io_clk_o
);
    logic [NUM_IN-1:0] level_low;
    logic              io_clk_en, asleep, running;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_ch
        ext_irq_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .clk_en_i    (io_clk_en),
            .run_i       (running),
            .pin_i       (pin_i[i]),
            .sense_i     (sense_i[2*i +: 2]),
            .en_i        (en_i[i]),
            .w1c_i       (flag_w1c_i[i]),
            .ack_i       (ack_i[i]),
            .flag_o      (flag_o[i]),
            .irq_o       (irq_o[i]),
            .level_low_o (level_low[i])
        );
    end

    ext_irq_wake_ctrl #(.DLY_1(DLY_1), .DLY_2(DLY_2), .DLY_3(DLY_3)) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_i (sleep_req_i),
        .wake_req_i  (|level_low),
        .dly_sel_i   (startup_sel_i),
        .run_o       (running),
        .io_clk_en_o (io_clk_en),
        .asleep_o    (asleep)
    );

    assign wake_o   = asleep & (|level_low);
    assign run_o    = running;
    assign io_clk_o = io_clk_en;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
// Property checker for ext_irq_ctrl, attached with bind below.
// Assumes: inputs are stable around the sampling edge.
module ext_irq_ctrl_chk #(
    parameter int NUM_IN = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_IN-1:0]   pin_i,
    input logic [2*NUM_IN-1:0] sense_i,
    input logic [NUM_IN-1:0]   flag_w1c_i,
    input logic [NUM_IN-1:0]   irq_o,
    input logic [NUM_IN-1:0]   flag_o,
    input logic                wake_o,
    input logic                run_o,
    input logic                io_clk_o
);
    // R1: first cycle out of reset shows the idle running state.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_o == '0 && run_o && io_clk_o && !wake_o));

    // R12: no request leaves the block unless the core is running.
    a_r12_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> (irq_o == '0));

    // R9: wake is only raised while the I/O clock is stopped.
    a_r9_wake_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !io_clk_o);

    // R8: no flag bit newly rises across an edge taken while asleep.
    a_r8_no_set_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        !io_clk_o |=> ((flag_o & ~$past(flag_o)) == '0));

    // R6: a clear strobe while asleep always takes effect.
    a_r6_clear_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_clk_o && (flag_w1c_i != '0)) |=> ((flag_o & $past(flag_w1c_i)) == '0));

    for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
        // R5: a flag never rises from an edge taken in low-level mode.
        a_r5_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_o[i]) |-> ($past(sense_i[2*i +: 2]) != 2'b00));

        // R2: a flag rise follows a pin change three to four samples back.
        a_r2_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_o[i]) |-> ($past(pin_i[i], 3) != $past(pin_i[i], 4)));
    end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .sense_i    (sense_i),
    .flag_w1c_i (flag_w1c_i),
    .irq_o      (irq_o),
    .flag_o     (flag_o),
    .wake_o     (wake_o),
    .run_o      (run_o),
    .io_clk_o   (io_clk_o)
);

// File: tb/tb_ext_irq_ctrl.sv
// Bench: behavioural reference model compared against the DUT every clock.
module tb_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_i = 2'b11;
    logic [3:0] sense_i = '0;
    logic [1:0] en_i = '0;
    logic [1:0] flag_w1c_i = '0;
    logic [1:0] ack_i = '0;
    logic       sleep_req_i = 1'b0;
    logic [1:0] startup_sel_i = '0;
    logic [1:0] irq_o, flag_o;
    logic       wake_o, run_o, io_clk_o;

    always #4 clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sense_i(sense_i), .en_i(en_i),
        .flag_w1c_i(flag_w1c_i), .ack_i(ack_i), .sleep_req_i(sleep_req_i),
        .startup_sel_i(startup_sel_i), .irq_o(irq_o), .flag_o(flag_o),
        .wake_o(wake_o), .run_o(run_o), .io_clk_o(io_clk_o)
    );

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R1";

    // Reference model: 0 running, 1 asleep, 2 starting up.
    int st = 0;
    int cnt = 0;
    int since_restart = 0;
    bit m_flag [2];
    bit hist [2][3];

    function automatic int delay_of(logic [1:0] s);
        case (s)
            2'd1: return 4;
            2'd2: return 64;
            2'd3: return 1024;
            default: return 0;
        endcase
    endfunction

    function automatic bit wants_edge(logic [1:0] s, bit older, bit newer);
        if (s == 2'b01) return older != newer;
        if (s == 2'b10) return older && !newer;
        if (s == 2'b11) return !older && newer;
        return 0;
    endfunction

    // Advance the model with the inputs present at this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            st = 0; cnt = 0; since_restart = 0;
            for (int c = 0; c < 2; c++) begin
                m_flag[c] = 0;
                for (int k = 0; k < 3; k++) hist[c][k] = 1;
            end
        end else begin
            bit running;
            bit any_low;
            running = (st != 1);
            any_low = 0;
            for (int c = 0; c < 2; c++) begin
                bit set;
                set = running && since_restart >= 3 &&
                      wants_edge(sense_i[2*c +: 2], hist[c][2], hist[c][1]);
                if (set) m_flag[c] = 1;
                else if (flag_w1c_i[c] || ack_i[c]) m_flag[c] = 0;
                if (running) begin
                    hist[c][2] = hist[c][1];
                    hist[c][1] = hist[c][0];
                    hist[c][0] = pin_i[c];
                end
                if (en_i[c] && sense_i[2*c +: 2] == 2'b00 && !pin_i[c]) any_low = 1;
            end
            if (running) since_restart++;
            else since_restart = 0;
            if (st == 0) begin
                if (sleep_req_i) st = 1;
            end else if (st == 1) begin
                if (any_low) begin
                    cnt = delay_of(startup_sel_i);
                    st = (cnt == 0) ? 0 : 2;
                end
            end else begin
                cnt--;
                if (cnt == 0) st = 0;
            end
        end
    end

    task automatic cmp(string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Compare every output a little after each edge.
    always @(posedge clk) begin
        #3;
        if (!done) begin
            logic [1:0] e_irq, e_flag;
            bit any_low;
            any_low = 0;
            for (int c = 0; c < 2; c++) begin
                bit lvl;
                lvl = (sense_i[2*c +: 2] == 2'b00);
                e_flag[c] = m_flag[c];
                e_irq[c]  = (st == 0) && en_i[c] && (lvl ? !pin_i[c] : m_flag[c]);
                if (en_i[c] && lvl && !pin_i[c]) any_low = 1;
            end
            cmp("flag_o", flag_o, e_flag);
            cmp("irq_o", irq_o, e_irq);
            cmp("wake_o", {1'b0, wake_o}, {1'b0, (st == 1) && any_low});
            cmp("run_o", {1'b0, run_o}, {1'b0, st == 0});
            cmp("io_clk_o", {1'b0, io_clk_o}, {1'b0, st != 1});
        end
    end

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=200000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_w1c(logic [1:0] m);
        flag_w1c_i = m; wait_n(1); flag_w1c_i = '0;
    endtask

    task automatic pulse_ack(logic [1:0] m);
        ack_i = m; wait_n(1); ack_i = '0;
    endtask

    task automatic go_sleep();
        sleep_req_i = 1'b1; wait_n(1); sleep_req_i = 1'b0; wait_n(2);
    endtask

    initial begin
        wait_n(5);
        // R1: reset state, checked during and after reset.
        rst_n = 1'b1;
        wait_n(4);

        // R2: falling-edge mode on input 0.
        tag = "R2";
        sense_i[1:0] = 2'b10; en_i = 2'b01; wait_n(2);
        pin_i[0] = 1'b0; wait_n(6);
        pin_i[0] = 1'b1; wait_n(6);
        // R6: write-one-to-clear.
        tag = "R6";
        pulse_w1c(2'b01); wait_n(3);

        // R3: rising-edge mode on input 1.
        tag = "R3";
        sense_i[3:2] = 2'b11; en_i = 2'b11; wait_n(2);
        pin_i[1] = 1'b0; wait_n(6);
        pin_i[1] = 1'b1; wait_n(6);
        pulse_ack(2'b10); wait_n(2);

        // R4: any-change mode, both directions, cleared by acknowledge.
        tag = "R4";
        sense_i[1:0] = 2'b01; wait_n(2);
        pin_i[0] = 1'b0; wait_n(6);
        pulse_ack(2'b01); wait_n(2);
        pin_i[0] = 1'b1; wait_n(6);
        // R6: clear held while a new edge lands: set must win.
        tag = "R6";
        flag_w1c_i = 2'b11; pin_i[0] = 1'b0; wait_n(6);
        flag_w1c_i = '0; wait_n(2);
        pulse_w1c(2'b01); wait_n(2);

        // R7: disabled input keeps its flag but raises no request.
        tag = "R7";
        en_i = 2'b00; pin_i[0] = 1'b1; wait_n(6);
        en_i = 2'b01; wait_n(3);
        pulse_w1c(2'b01); wait_n(2);

        // R5: low-level mode follows the pin with no flag.
        tag = "R5";
        sense_i[3:2] = 2'b00; en_i = 2'b11; wait_n(3);
        pin_i[1] = 1'b0; wait_n(4);
        pin_i[1] = 1'b1; wait_n(4);

        // R8 / R9: edges on input 0 while asleep are ignored and do not wake.
        tag = "R8";
        sense_i[1:0] = 2'b10; wait_n(3);
        go_sleep();
        tag = "R9";
        pin_i[0] = 1'b0; wait_n(6);
        pin_i[0] = 1'b1; wait_n(4);

        // R10: level wake with a 4-clock start-up; R12 while starting.
        tag = "R10";
        startup_sel_i = 2'd1;
        pin_i[1] = 1'b0; wait_n(12);
        pin_i[1] = 1'b1; wait_n(4);

        // R11: level gone before the 64-clock start-up ends.
        tag = "R11";
        go_sleep();
        startup_sel_i = 2'd2;
        pin_i[1] = 1'b0; wait_n(2);
        pin_i[1] = 1'b1; wait_n(80);

        // R12 / R10: longest start-up, level held throughout.
        tag = "R12";
        go_sleep();
        startup_sel_i = 2'd3;
        pin_i[1] = 1'b0; wait_n(1030);
        pin_i[1] = 1'b1; wait_n(4);

        // R10: zero start-up returns to running at once.
        tag = "R10";
        go_sleep();
        startup_sel_i = 2'd0;
        pin_i[1] = 1'b0; wait_n(4);
        pin_i[1] = 1'b1; wait_n(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule